// File: doc/BRIEF.md
# Luminance Mean-Shift Window Tracker

This block follows a rectangular target from frame to frame. A detector hands it a starting rectangle. The block reads the pixels under that rectangle and builds a kernel-weighted luminance histogram of them, which becomes the target model. When a new frame is ready, a track command makes the block iterate. Each iteration builds the same kind of histogram at the current window position. It then gives every pixel in the window a weight, the ratio of the target bin to the candidate bin, and moves the window to the weighted centroid. The window keeps moving toward the region that looks most like the learned target.

Pixels are read one at a time over a simple request and response pair, so the block works with any frame store that has any response latency. Each RGB pixel is reduced to an 8-bit luma value. Only its upper four bits select one of 16 histogram bins. The block keeps the window inside the frame and never changes its size. At the end of each command it gives a one-cycle completion pulse along with the rectangle and the number of iterations used.

Top module: `msTracker`

## Requirements
- R1: After reset, `doneP` and `pixReq` are low, the reported rectangle is all zeros and `iterUsed` is zero.
- R2: Each fetched pixel is reduced to luma Y = (77·R + 150·G + 29·B) >> 8, where R = `pixRgb[23:16]`, G = `pixRgb[15:8]` and B = `pixRgb[7:0]`. Its histogram bin is Y[7:4], which gives 16 bins.
- R3: A pulse on `initValid` while the block is idle loads the rectangle. x is limited to FRAME_W − width and y to FRAME_H − height. The block then reads every window pixel once to build the target histogram. It then pulses `doneP` with the loaded rectangle and `iterUsed` = 0.
- R4: A pixel at column i and row j of the window contributes max(0, hSq − dx² − dy²) to its bin. Here dx = i − (width>>1), dy = j − (height>>1) and hSq = (width>>1)² + (height>>1)².
- R5: Pixel fetches hold `pixReq` high for exactly one cycle and go in row-major order inside the window. The block waits any number of cycles for `pixValid`. A learn command reads width·height pixels. A track command reads 2·width·height pixels per iteration: one candidate pass and one weight pass.
- R6: In the weight pass each pixel gets the weight (T[bin] << 8) / C[bin], with T the target histogram and C the candidate histogram. The weight is 0 when C[bin] is 0. Every window pixel takes part, including pixels whose kernel value is zero.
- R7: The shift in each axis is Σ(w·d) / Σ(w), truncated toward zero, with d the dx or dy of R4. The shift is 0 when Σw is 0.
- R8: After a shift, x is limited to [0, FRAME_W − width] and y to [0, FRAME_H − height]. The window never leaves the frame.
- R9: Tracking stops after an iteration whose unclamped shift is zero in both axes, or after MAX_ITER (8) iterations, whichever comes first. `iterUsed` reports the number of iterations performed.
- R10: `doneP` lasts one cycle. Width and height in the result equal the loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| initValid | input | 1 | Load a rectangle and learn the target model |
| initX | input | 6 | Initial left edge |
| initY | input | 6 | Initial top edge |
| initW | input | 5 | Window width (1 to MAX_DIM) |
| initH | input | 5 | Window height (1 to MAX_DIM) |
| trackStart | input | 1 | Start mean-shift iteration on the current frame |
| pixReq | output | 1 | One-cycle pixel read request |
| pixX | output | 6 | Requested pixel column |
| pixY | output | 6 | Requested pixel row |
| pixValid | input | 1 | Pixel response strobe |
| pixRgb | input | 24 | Pixel colour, R in the top byte |
| doneP | output | 1 | One-cycle completion pulse |
| outX | output | 6 | Result left edge |
| outY | output | 6 | Result top edge |
| outW | output | 5 | Result width |
| outH | output | 5 | Result height |
| iterUsed | output | 4 | Iterations performed by the last command |

## Verification
The tracker is driven with several frames:
- A textured blob tracked on the frame it was learned on, which must settle in place.
- The same blob displaced by a few pixels, which shows whether the window really climbs toward the target rather than staying put.
- A flat single-colour frame, where every weight is equal and the shift reduces to the truncated mean offset. This separates the rounding rule from the histogram logic.
- A blob pushed past the top-left corner and another past the bottom-right corner, which exercise the clamp at both limits.
- A horizontal brightness ramp that is offset between learning and tracking, which produces a chain of small moves and tests the iteration count.

Each completion is compared with an independent model of the requirements, which covers the rectangle, the iteration count and the number of fetches. The fetch response latency varies from pixel to pixel.

// File: rtl/msTrackPkg.sv
package msTrackPkg;
  localparam int NBINS = 16;
  localparam int FRAC  = 8;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadBox;
    logic clrTgt;
    logic clrCand;
    logic histAdd;
    logic toTgt;
    logic sumAdd;
    logic applyShift;
  } msCtl_t;
endpackage

// File: rtl/msTrackCtrl.sv
module msTrackCtrl
  import msTrackPkg::*;
#(
  parameter int MAX_ITER = 8,
  parameter int DW       = 5,
  parameter int IW       = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          initValid,
  input  logic          trackStart,
  input  logic          pixValid,
  input  logic          shiftZero,
  input  logic [DW-1:0] boxW,
  input  logic [DW-1:0] boxH,
  output msCtl_t        ctl,
  output logic [DW-1:0] scanI,
  output logic [DW-1:0] scanJ,
  output logic          pixReq,
  output logic          doneP,
  output logic [IW-1:0] iterUsed
);
  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_SHIFT, S_CHECK, S_DONE} st_e;
  typedef enum logic [1:0] {PH_TGT, PH_CAND, PH_WGT} ph_e;

  st_e  st;
  ph_e  ph;
  logic rowEnd, lastPix, iterMax;

  assign rowEnd  = (scanI == boxW - 1'b1);
  assign lastPix = rowEnd && (scanJ == boxH - 1'b1);
  assign iterMax = (iterUsed == IW'(MAX_ITER));
  assign pixReq  = (st == S_REQ);
  assign doneP   = (st == S_DONE);

  always_comb begin
    ctl            = '0;
    ctl.loadBox    = (st == S_IDLE) && initValid;
    ctl.clrTgt     = (st == S_IDLE) && initValid;
    ctl.clrCand    = ((st == S_IDLE) && !initValid && trackStart) ||
                     ((st == S_CHECK) && !shiftZero && !iterMax);
    ctl.histAdd    = (st == S_WAIT) && pixValid && (ph != PH_WGT);
    ctl.toTgt      = (ph == PH_TGT);
    ctl.sumAdd     = (st == S_WAIT) && pixValid && (ph == PH_WGT);
    ctl.applyShift = (st == S_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= S_IDLE;
      ph       <= PH_TGT;
      scanI    <= '0;
      scanJ    <= '0;
      iterUsed <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (initValid) begin
            ph <= PH_TGT; iterUsed <= '0; st <= S_REQ;
          end else if (trackStart) begin
            ph <= PH_CAND; iterUsed <= '0; st <= S_REQ;
          end
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: begin
          if (pixValid) begin
            if (lastPix) begin
              scanI <= '0;
              scanJ <= '0;
              case (ph)
                PH_TGT:  st <= S_DONE;
                PH_CAND: begin ph <= PH_WGT; st <= S_REQ; end
                default: st <= S_SHIFT;
              endcase
            end else begin
              st <= S_REQ;
              if (rowEnd) begin
                scanI <= '0;
                scanJ <= scanJ + 1'b1;
              end else begin
                scanI <= scanI + 1'b1;
              end
            end
          end
        end
        S_SHIFT: begin
          iterUsed <= iterUsed + 1'b1;
          st       <= S_CHECK;
        end
        S_CHECK: begin
          if (shiftZero || iterMax) st <= S_DONE;
          else begin ph <= PH_CAND; st <= S_REQ; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5: a request lasts a single cycle
  p_req_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    pixReq |=> !pixReq);
  // R5: fetch coordinates stay inside the window
  p_scan_in_box_r5: assert property (@(posedge clk) disable iff (!rstN)
    pixReq |-> (scanI < boxW) && (scanJ < boxH));
  // R10: completion is a pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP);
  // R9: iteration count never passes the cap
  p_iter_cap_r9: assert property (@(posedge clk) disable iff (!rstN)
    int'(iterUsed) <= MAX_ITER);
endmodule

// File: rtl/msTrackDp.sv
module msTrackDp
  import msTrackPkg::*;
#(
  parameter int FRAME_W = 64,
  parameter int FRAME_H = 48,
  parameter int CW      = 6,
  parameter int DW      = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  msCtl_t        ctl,
  input  logic [DW-1:0] scanI,
  input  logic [DW-1:0] scanJ,
  input  logic [CW-1:0] initX,
  input  logic [CW-1:0] initY,
  input  logic [DW-1:0] initW,
  input  logic [DW-1:0] initH,
  input  logic [23:0]   pixRgb,
  output logic [CW-1:0] pixX,
  output logic [CW-1:0] pixY,
  output logic [CW-1:0] boxX,
  output logic [CW-1:0] boxY,
  output logic [DW-1:0] boxW,
  output logic [DW-1:0] boxH,
  output logic          shiftZero
);
  localparam int KW     = 2 * DW;
  localparam int HIST_W = KW + 2 * DW;
  localparam int WGT_W  = HIST_W + FRAC;
  localparam int SUM_W  = WGT_W + 3 * DW + 1;

  logic [HIST_W-1:0] tgtHist  [NBINS];
  logic [HIST_W-1:0] candHist [NBINS];
  logic signed [SUM_W-1:0] sumW, sumWx, sumWy;

  int unsigned lumaI;
  logic [3:0]  pixBin;
  int          dxI, dyI, hSqI, kI;
  logic [KW-1:0]     kern;
  logic [HIST_W-1:0] candSel, tgtSel;
  logic [WGT_W-1:0]  wgt;
  longint shXL, shYL, nxL, nyL, lxL, lyL;

  assign pixX = boxX + CW'(scanI);
  assign pixY = boxY + CW'(scanJ);

  always_comb begin
    lumaI   = (77 * int'(pixRgb[23:16]) + 150 * int'(pixRgb[15:8]) + 29 * int'(pixRgb[7:0])) >> 8;
    pixBin  = lumaI[7:4];
    dxI     = int'(scanI) - int'(boxW >> 1);
    dyI     = int'(scanJ) - int'(boxH >> 1);
    hSqI    = int'(boxW >> 1) * int'(boxW >> 1) + int'(boxH >> 1) * int'(boxH >> 1);
    kI      = hSqI - dxI * dxI - dyI * dyI;
    kern    = (kI > 0) ? KW'(kI) : '0;
    candSel = candHist[pixBin];
    tgtSel  = tgtHist[pixBin];
    wgt     = (candSel == '0) ? '0 : {tgtSel, {FRAC{1'b0}}} / WGT_W'(candSel);
    shXL    = (sumW == '0) ? 64'sd0 : longint'(sumWx) / longint'(sumW);
    shYL    = (sumW == '0) ? 64'sd0 : longint'(sumWy) / longint'(sumW);
    nxL     = longint'(boxX) + shXL;
    nyL     = longint'(boxY) + shYL;
    if (nxL < 0) nxL = 0;
    if (nyL < 0) nyL = 0;
    if (nxL > longint'(FRAME_W) - longint'(boxW)) nxL = longint'(FRAME_W) - longint'(boxW);
    if (nyL > longint'(FRAME_H) - longint'(boxH)) nyL = longint'(FRAME_H) - longint'(boxH);
    lxL = longint'(initX);
    lyL = longint'(initY);
    if (lxL > longint'(FRAME_W) - longint'(initW)) lxL = longint'(FRAME_W) - longint'(initW);
    if (lyL > longint'(FRAME_H) - longint'(initH)) lyL = longint'(FRAME_H) - longint'(initH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      boxX <= '0; boxY <= '0; boxW <= '0; boxH <= '0;
      sumW <= '0; sumWx <= '0; sumWy <= '0;
      shiftZero <= 1'b0;
      for (int b = 0; b < NBINS; b++) begin
        tgtHist[b]  <= '0;
        candHist[b] <= '0;
      end
    end else begin
      if (ctl.loadBox) begin
        boxX <= CW'(lxL); boxY <= CW'(lyL);
        boxW <= initW;    boxH <= initH;
      end
      if (ctl.clrTgt)
        for (int b = 0; b < NBINS; b++) tgtHist[b] <= '0;
      if (ctl.clrCand) begin
        for (int b = 0; b < NBINS; b++) candHist[b] <= '0;
        sumW <= '0; sumWx <= '0; sumWy <= '0;
      end
      if (ctl.histAdd) begin
        if (ctl.toTgt) tgtHist[pixBin]  <= tgtHist[pixBin]  + HIST_W'(kern);
        else           candHist[pixBin] <= candHist[pixBin] + HIST_W'(kern);
      end
      if (ctl.sumAdd) begin
        sumW  <= sumW  + SUM_W'(wgt);
        sumWx <= sumWx + SUM_W'(longint'(wgt) * longint'(dxI));
        sumWy <= sumWy + SUM_W'(longint'(wgt) * longint'(dyI));
      end
      if (ctl.applyShift) begin
        boxX      <= CW'(nxL);
        boxY      <= CW'(nyL);
        shiftZero <= (shXL == 0) && (shYL == 0);
      end
    end
  end

  // R8: the window is always inside the frame
  p_box_in_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    (int'(boxX) + int'(boxW) <= FRAME_W) && (int'(boxY) + int'(boxH) <= FRAME_H));
  // R10: moving the window never alters its size
  p_size_kept_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.applyShift |=> $stable(boxW) && $stable(boxH));
endmodule

// File: rtl/msTracker.sv
module msTracker
  import msTrackPkg::*;
#(
  parameter int FRAME_W  = 64,
  parameter int FRAME_H  = 48,
  parameter int MAX_DIM  = 16,
  parameter int MAX_ITER = 8,
  localparam int CW = $clog2((FRAME_W > FRAME_H) ? FRAME_W : FRAME_H),
  localparam int DW = $clog2(MAX_DIM) + 1,
  localparam int IW = $clog2(MAX_ITER) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          initValid,
  input  logic [CW-1:0] initX,
  input  logic [CW-1:0] initY,
  input  logic [DW-1:0] initW,
  input  logic [DW-1:0] initH,
  input  logic          trackStart,
  output logic          pixReq,
  output logic [CW-1:0] pixX,
  output logic [CW-1:0] pixY,
  input  logic          pixValid,
  input  logic [23:0]   pixRgb,
  output logic          doneP,
  output logic [CW-1:0] outX,
  output logic [CW-1:0] outY,
  output logic [DW-1:0] outW,
  output logic [DW-1:0] outH,
  output logic [IW-1:0] iterUsed
);
  msCtl_t        ctl;
  logic [DW-1:0] scanI, scanJ;
  logic          shiftZero;

  msTrackCtrl #(.MAX_ITER(MAX_ITER), .DW(DW), .IW(IW)) ctrl_i (
    .clk(clk), .rstN(rstN), .initValid(initValid), .trackStart(trackStart),
    .pixValid(pixValid), .shiftZero(shiftZero), .boxW(outW), .boxH(outH),
    .ctl(ctl), .scanI(scanI), .scanJ(scanJ), .pixReq(pixReq), .doneP(doneP),
    .iterUsed(iterUsed)
  );

  msTrackDp #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .CW(CW), .DW(DW)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .scanI(scanI), .scanJ(scanJ),
    .initX(initX), .initY(initY), .initW(initW), .initH(initH),
    .pixRgb(pixRgb), .pixX(pixX), .pixY(pixY),
    .boxX(outX), .boxY(outY), .boxW(outW), .boxH(outH), .shiftZero(shiftZero)
  );
endmodule

// File: tb/msTracker_tb_top.sv
module msTracker_tb_top;
  localparam int FW = 64;
  localparam int FH = 48;
  localparam int MAXIT = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        initValid = 1'b0, trackStart = 1'b0, pixValid = 1'b0;
  logic [5:0]  initX = '0, initY = '0;
  logic [4:0]  initW = '0, initH = '0;
  logic [23:0] pixRgb = '0;
  logic        pixReq, doneP;
  logic [5:0]  pixX, pixY, outX, outY;
  logic [4:0]  outW, outH;
  logic [3:0]  iterUsed;

  always #5 clk = ~clk;

  msTracker dut_i (
    .clk(clk), .rstN(rstN), .initValid(initValid), .initX(initX), .initY(initY),
    .initW(initW), .initH(initH), .trackStart(trackStart), .pixReq(pixReq),
    .pixX(pixX), .pixY(pixY), .pixValid(pixValid), .pixRgb(pixRgb), .doneP(doneP),
    .outX(outX), .outY(outY), .outW(outW), .outH(outH), .iterUsed(iterUsed)
  );

  int vecCnt = 0, failCnt = 0, fetchCnt = 0, curFrame = 0;

  typedef struct {
    int    x, y, w, h, it, fetch;
    string tag;
  } exp_t;
  exp_t expQ[$];

  task automatic check(string req, string what, int act, int exp);
    vecCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------- frame generator ----------
  function automatic logic [23:0] frameRgb(int sel, int x, int y);
    int bx, by, v, dx, dy;
    case (sel)
      0: begin bx = 20; by = 12; end
      1: begin bx = 23; by = 14; end
      2: begin bx = 3;  by = 3;  end
      3: begin bx = -2; by = -2; end
      4: begin bx = 56; by = 40; end
      5: begin bx = 60; by = 44; end
      default: begin bx = 0; by = 0; end
    endcase
    if (sel == 6) return {8'd90, 8'd90, 8'd90};
    if (sel == 7 || sel == 8) begin
      v = (sel == 7) ? x * 3 : (x + 6) * 3;
      if (v > 255) v = 255;
      return {v[7:0], v[7:0], v[7:0]};
    end
    dx = x - bx; dy = y - by;
    if (dx >= 0 && dx < 6 && dy >= 0 && dy < 6) begin
      logic [7:0] r, g, b;
      r = 8'(60 + dx * 30); g = 8'(200 - dy * 25); b = 8'(40 + (dx + dy) * 10);
      return {r, g, b};
    end
    return {8'd20, 8'd30, 8'd40};
  endfunction

  // ---------- reference model from the requirements ----------
  longint tgtM [16];
  int mX, mY, mW, mH;

  function automatic int binOf(logic [23:0] p);          // R2
    int yv;
    yv = (77 * int'(p[23:16]) + 150 * int'(p[15:8]) + 29 * int'(p[7:0])) >> 8;
    return (yv >> 4) & 15;
  endfunction

  function automatic longint kernOf(int i, int j, int w, int h);  // R4
    int dx, dy, hs, k;
    dx = i - w / 2; dy = j - h / 2;
    hs = (w / 2) * (w / 2) + (h / 2) * (h / 2);
    k = hs - dx * dx - dy * dy;
    return (k > 0) ? longint'(k) : 0;
  endfunction

  task automatic modelLearn(int sel, int x, int y, int w, int h);
    mW = w; mH = h;
    mX = (x > FW - w) ? FW - w : x;
    mY = (y > FH - h) ? FH - h : y;
    for (int b = 0; b < 16; b++) tgtM[b] = 0;
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++)
        tgtM[binOf(frameRgb(sel, mX + i, mY + j))] += kernOf(i, j, w, h);
  endtask

  task automatic modelTrack(int sel, output int its);
    longint cand [16];
    longint sw, sx, sy, wg, shx, shy, nx, ny;
    int bn;
    its = 0;
    forever begin
      for (int b = 0; b < 16; b++) cand[b] = 0;
      for (int j = 0; j < mH; j++)
        for (int i = 0; i < mW; i++)
          cand[binOf(frameRgb(sel, mX + i, mY + j))] += kernOf(i, j, mW, mH);
      sw = 0; sx = 0; sy = 0;
      for (int j = 0; j < mH; j++)
        for (int i = 0; i < mW; i++) begin
          bn = binOf(frameRgb(sel, mX + i, mY + j));
          wg = (cand[bn] == 0) ? 0 : (tgtM[bn] * 256) / cand[bn];   // R6
          sw += wg;
          sx += wg * (i - mW / 2);
          sy += wg * (j - mH / 2);
        end
      shx = (sw == 0) ? 0 : sx / sw;                               // R7
      shy = (sw == 0) ? 0 : sy / sw;
      nx = mX + shx; ny = mY + shy;                                // R8
      if (nx < 0) nx = 0;
      if (ny < 0) ny = 0;
      if (nx > FW - mW) nx = FW - mW;
      if (ny > FH - mH) ny = FH - mH;
      mX = int'(nx); mY = int'(ny);
      its++;
      if ((shx == 0 && shy == 0) || its == MAXIT) break;           // R9
    end
  endtask

  // ---------- memory responder ----------
  initial begin
    int lat;
    forever begin
      if (pixReq === 1'b1) begin
        int ax, ay;
        ax = int'(pixX); ay = int'(pixY);
        fetchCnt++;
        lat = fetchCnt % 3;
        @(negedge clk);
        repeat (lat) @(negedge clk);
        pixRgb   = frameRgb(curFrame, ax, ay);
        pixValid = 1'b1;
        @(negedge clk);
        pixValid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  // ---------- monitor / scoreboard ----------
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && doneP === 1'b1) begin
        if (expQ.size() == 0) begin
          check("R10", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check("R7 R8", {e.tag, " x"}, int'(outX), e.x);
          check("R7 R8", {e.tag, " y"}, int'(outY), e.y);
          check("R10", {e.tag, " w"}, int'(outW), e.w);
          check("R10", {e.tag, " h"}, int'(outH), e.h);
          check("R9", {e.tag, " iterations"}, int'(iterUsed), e.it);
          check("R5 R6", {e.tag, " fetch count"}, fetchCnt, e.fetch);
        end
      end
    end
  end

  // ---------- driver ----------
  task automatic waitDone();
    @(negedge clk);
    while (doneP !== 1'b1) @(negedge clk);
    @(negedge clk);
    check("R10", "done is one cycle", int'(doneP), 0);
  endtask

  task automatic doLearn(int sel, int x, int y, int w, int h, string tag);
    exp_t e;
    modelLearn(sel, x, y, w, h);
    e.x = mX; e.y = mY; e.w = w; e.h = h; e.it = 0; e.fetch = w * h; e.tag = tag;
    expQ.push_back(e);                       // R3
    curFrame = sel; fetchCnt = 0;
    @(negedge clk);
    initX = 6'(x); initY = 6'(y); initW = 5'(w); initH = 5'(h);
    initValid = 1'b1;
    @(negedge clk);
    initValid = 1'b0;
    waitDone();
  endtask

  task automatic doTrack(int sel, string tag);
    exp_t e;
    int its;
    modelTrack(sel, its);
    e.x = mX; e.y = mY; e.w = mW; e.h = mH; e.it = its;
    e.fetch = 2 * mW * mH * its; e.tag = tag;
    expQ.push_back(e);
    curFrame = sel; fetchCnt = 0;
    @(negedge clk);
    trackStart = 1'b1;
    @(negedge clk);
    trackStart = 1'b0;
    waitDone();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "doneP", int'(doneP), 0);
    check("R1", "pixReq", int'(pixReq), 0);
    check("R1", "outX", int'(outX), 0);
    check("R1", "outW", int'(outW), 0);
    check("R1", "iterUsed", int'(iterUsed), 0);

    doLearn(0, 17, 9, 12, 12, "R3 learn blob");
    doTrack(0, "R9 same frame");
    doTrack(1, "R7 moved blob");
    doTrack(1, "R7 moved blob again");
    doLearn(6, 10, 10, 9, 9, "R3 flat odd");
    doTrack(6, "R6 flat odd");
    doLearn(6, 10, 10, 8, 8, "R3 flat even");
    doTrack(6, "R7 flat even");
    doLearn(2, 1, 1, 8, 8, "R3 corner learn");
    doTrack(3, "R8 clamp low");
    doLearn(4, 63, 47, 8, 8, "R3 clamped load");
    doTrack(5, "R8 clamp high");
    doLearn(7, 30, 20, 8, 8, "R2 ramp learn");
    doTrack(8, "R9 ramp track");
    doTrack(8, "R9 ramp settle");

    check("R10", "no result left over", expQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failCnt++;
    vecCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end
endmodule